// File: doc/BRIEF.md
# Capture-Mode Timer/Counter Channel

This block is a single counter channel that measures time between signal edges. A counter, 16 bits wide by default, advances on a counting tick. The tick comes from one of five fixed divisions of the system clock or from one of three external clock inputs. The tick source can be inverted, and it can be ANDed with an external gate level. Edges on the `tioa` input copy the running count into one of two capture registers. An edge on `tioa` or `tiob`, a command from software, or a match against a compare value brings the counter back to zero.

Software reaches the channel through a word-addressed register port. Reads return data combinationally in the same cycle. Writes and the clear-on-read side effects take effect on the clock edge. Eight event flags are latched in a status register. A mask selects which flags drive the level interrupt output `irq`. All external inputs are asynchronous and pass through a two-stage synchronizer before use.

Register word addresses: 0 command (write), 1 mode (read/write), 2 counter value (read), 3 capture A (read), 4 capture B (read), 5 compare C (read/write), 6 status (read, clears on read), 7 mask set (write), 8 mask clear (write), 9 mask (read). Write-only addresses and unused addresses read as zero.

Top module: `tc_capture_channel`

## Requirements
- R1: After reset, the mode, counter, capture A, capture B, status and mask registers all read zero, and `irq` is low.
- R2: Mode bits 2:0 choose the counting tick. 0 = clk/2, 1 = clk/8, 2 = clk/32, 3 = clk/128, 4 = clk/1024, and 5, 6, 7 = rising edges of `xc[0]`, `xc[1]`, `xc[2]`. Over any window that is a whole number of divider periods, an internal source advances the counter by exactly the window divided by its ratio.
- R3: The counter moves only while it is both enabled and started. Command bit 0 enables. Command bit 1 disables, and it wins over bit 0 in the same write. Command bit 2 clears the counter to zero and starts it. Enabling alone does not start counting.
- R4: With mode bit 3 at 1, the counter advances on the falling edge of the selected source instead of the rising edge.
- R5: Mode bits 5:4 gate the source. 0 = no gate, and 1, 2, 3 AND the source with `xc[0]`, `xc[1]`, `xc[2]`. While the gate is low, the counter does not move.
- R6: A tick with the counter equal to compare C sets status bit 4. With mode bit 14 set, that tick also loads zero, giving a cycle of C+1 ticks. A tick with the counter equal to capture A or capture B sets status bit 2 or status bit 3.
- R7: A tick that wraps the counter from all ones to zero sets status bit 0.
- R8: Mode bits 17:16 (capture A) and 19:18 (capture B) pick the `tioa` edge that loads the counter: 0 none, 1 rising, 2 falling, 3 both. A load into A sets status bit 5, and a load into B sets status bit 6.
- R9: A load into A or B while that register's load flag is still set sets status bit 1.
- R10: A load into B stops the counter when mode bit 6 is set, and a later command bit 2 restarts it. A load into B disables the counter when mode bit 7 is set, and only command bit 0 re-enables it.
- R11: Mode bits 9:8 pick the trigger edge (0 none, 1 rising, 2 falling, 3 both), and mode bit 10 picks the trigger input (0 `tioa`, 1 `tiob`). A trigger clears the counter, starts it and sets status bit 7.
- R12: Reading status returns the latched flags and clears them. Events from the cycle of the read remain set.
- R13: A 1 in bit n of a mask-set write sets mask bit n, and a 1 in a mask-clear write clears it. Zero bits have no effect. `irq` is high exactly while some status bit and its mask bit are both set.
- R14: The register addresses are the ones listed above. Write-only registers and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers the clear of status on read) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| tioa | input | 1 | Capture and trigger input A (asynchronous) |
| tiob | input | 1 | Trigger input B (asynchronous) |
| xc | input | 3 | External clock and gate inputs (asynchronous) |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with an 8-bit counter. With that width, a wrap from all ones to zero takes only 256 ticks, so the overflow flag can be reached with the clk/2 source in about 500 cycles. The 16-bit default would need more than 130,000 cycles for the same check. The prescaler taps are checked by taking counter differences over windows that are exact multiples of each ratio. The external clock inputs drive single ticks, so the compare, capture, stop, disable and trigger sequences can be checked at exact counts.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int BUS_W = 32;
    localparam int NEV   = 8;
    localparam int DIV_W = 10;

    typedef struct packed {
        logic [11:0] r31_20;
        logic [1:0]  ldb_sel;
        logic [1:0]  lda_sel;
        logic        r15;
        logic        rc_restart;
        logic [2:0]  r13_11;
        logic        trg_from_b;
        logic [1:0]  trg_edge;
        logic        off_on_b;
        logic        hold_on_b;
        logic [1:0]  gate_sel;
        logic        clk_inv;
        logic [2:0]  clk_src;
    } mode_t;

    typedef enum logic [3:0] {
        A_CMD   = 4'd0,
        A_MODE  = 4'd1,
        A_CNT   = 4'd2,
        A_CAPA  = 4'd3,
        A_CAPB  = 4'd4,
        A_CMPC  = 4'd5,
        A_STAT  = 4'd6,
        A_MSET  = 4'd7,
        A_MCLR  = 4'd8,
        A_MASK  = 4'd9
    } addr_e;

    localparam int EV_WRAP = 0;
    localparam int EV_OVRN = 1;
    localparam int EV_CMPA = 2;
    localparam int EV_CMPB = 3;
    localparam int EV_CMPC = 4;
    localparam int EV_LDA  = 5;
    localparam int EV_LDB  = 6;
    localparam int EV_TRG  = 7;

    // Divider bit whose level forms the selected internal source.
    function automatic logic [3:0] tap_bit(input logic [2:0] sel);
        case (sel)
            3'd0:    return 4'd0;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd6;
            default: return 4'd9;
        endcase
    endfunction

    // Edge selector: bit 0 rising, bit 1 falling.
    function automatic logic edge_hit(input logic [1:0] how,
                                      input logic rise, input logic fall);
        return (how[0] & rise) | (how[1] & fall);
    endfunction

endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tc_clk_sel.sv
module tc_clk_sel
    import tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] clk_src,
    input  logic       clk_inv,
    input  logic [1:0] gate_sel,
    input  logic [2:0] xc_lvl,
    output logic       tick
);
    logic [DIV_W-1:0] div_cnt;
    logic             src_lvl, gate_lvl, lvl, lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            lvl_q   <= 1'b0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            lvl_q   <= lvl;
        end
    end

    always_comb begin
        case (clk_src)
            3'd5:    src_lvl = xc_lvl[0];
            3'd6:    src_lvl = xc_lvl[1];
            3'd7:    src_lvl = xc_lvl[2];
            default: src_lvl = div_cnt[tap_bit(clk_src)];
        endcase
        case (gate_sel)
            2'd1:    gate_lvl = xc_lvl[0];
            2'd2:    gate_lvl = xc_lvl[1];
            2'd3:    gate_lvl = xc_lvl[2];
            default: gate_lvl = 1'b1;
        endcase
    end

    assign lvl  = src_lvl & gate_lvl;
    assign tick = clk_inv ? (~lvl & lvl_q) : (lvl & ~lvl_q);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!tick || (clk_inv != $past(clk_inv))));
endmodule

// File: rtl/tc_core.sv
module tc_core
    import tc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             hold_on_b,
    input  logic             off_on_b,
    input  logic [1:0]       trg_edge,
    input  logic             trg_from_b,
    input  logic             rc_restart,
    input  logic [1:0]       lda_sel,
    input  logic [1:0]       ldb_sel,
    input  logic [CNT_W-1:0] rc,
    input  logic             cmd_on,
    input  logic             cmd_off,
    input  logic             cmd_kick,
    input  logic             tioa_lvl,
    input  logic             tiob_lvl,
    input  logic             lda_pend,
    input  logic             ldb_pend,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic [NEV-1:0]   evt
);
    logic en, sta, tioa_q, tiob_q;
    logic a_rise, a_fall, b_rise, b_fall;
    logic ext_trg, trig, step, hit_a, hit_b, hit_c, restart, wrap, lda, ldb;

    assign a_rise  = tioa_lvl & ~tioa_q;
    assign a_fall  = ~tioa_lvl & tioa_q;
    assign b_rise  = tiob_lvl & ~tiob_q;
    assign b_fall  = ~tiob_lvl & tiob_q;
    assign ext_trg = trg_from_b ? edge_hit(trg_edge, b_rise, b_fall)
                                : edge_hit(trg_edge, a_rise, a_fall);
    assign trig    = cmd_kick | ext_trg;
    assign step    = tick & en & sta;
    assign hit_a   = step & (cnt == cap_a);
    assign hit_b   = step & (cnt == cap_b);
    assign hit_c   = step & (cnt == rc);
    assign restart = hit_c & rc_restart;
    assign wrap    = step & ~restart & (&cnt);
    assign lda     = edge_hit(lda_sel, a_rise, a_fall);
    assign ldb     = edge_hit(ldb_sel, a_rise, a_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            cap_a  <= '0;
            cap_b  <= '0;
            en     <= 1'b0;
            sta    <= 1'b0;
            tioa_q <= 1'b0;
            tiob_q <= 1'b0;
        end else begin
            tioa_q <= tioa_lvl;
            tiob_q <= tiob_lvl;
            if (trig || restart) cnt <= '0;
            else if (step)       cnt <= cnt + 1'b1;
            if (lda) cap_a <= cnt;
            if (ldb) cap_b <= cnt;
            if (cmd_off || (ldb && off_on_b)) en <= 1'b0;
            else if (cmd_on)                  en <= 1'b1;
            if (trig)                   sta <= 1'b1;
            else if (ldb && hold_on_b)  sta <= 1'b0;
        end
    end

    always_comb begin
        evt          = '0;
        evt[EV_WRAP] = wrap;
        evt[EV_OVRN] = (lda & lda_pend) | (ldb & ldb_pend);
        evt[EV_CMPA] = hit_a;
        evt[EV_CMPB] = hit_b;
        evt[EV_CMPC] = hit_c;
        evt[EV_LDA]  = lda;
        evt[EV_LDB]  = ldb;
        evt[EV_TRG]  = ext_trg;
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig && !step) |=> $stable(cnt));
    // R6
    rc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (step && rc_restart && (cnt == rc) && !trig) |=> (cnt == '0));
    // R10
    hold_on_b_chk: assert property (@(posedge clk) disable iff (rst)
        (ldb && hold_on_b && !trig) |=> !sta);
    // R11
    trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cnt == '0));
endmodule

// File: rtl/tc_capture_channel.sv
module tc_capture_channel
    import tc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tioa,
    input  logic             tiob,
    input  logic [2:0]       xc,
    output logic             irq
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in, lvl;
    mode_t            mode_q;
    logic [CNT_W-1:0] rc_q, cnt, cap_a, cap_b;
    logic [NEV-1:0]   stat_q, mask_q, evt;
    logic             tick, rd_stat, wr_cmd, wr_mset, wr_mclr;

    assign raw_in = {tiob, tioa, xc};

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        tc_sync #(.STAGES(2)) i_sync (
            .clk(clk), .rst(rst), .din(raw_in[i]), .dout(lvl[i])
        );
    end

    tc_clk_sel i_clk_sel (
        .clk(clk), .rst(rst),
        .clk_src(mode_q.clk_src), .clk_inv(mode_q.clk_inv),
        .gate_sel(mode_q.gate_sel), .xc_lvl(lvl[2:0]), .tick(tick)
    );

    assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
    assign wr_mset = bus_wr && (bus_addr == A_MSET);
    assign wr_mclr = bus_wr && (bus_addr == A_MCLR);
    assign rd_stat = bus_rd && (bus_addr == A_STAT);

    tc_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst(rst), .tick(tick),
        .hold_on_b(mode_q.hold_on_b), .off_on_b(mode_q.off_on_b),
        .trg_edge(mode_q.trg_edge), .trg_from_b(mode_q.trg_from_b),
        .rc_restart(mode_q.rc_restart),
        .lda_sel(mode_q.lda_sel), .ldb_sel(mode_q.ldb_sel), .rc(rc_q),
        .cmd_on(wr_cmd & bus_wdata[0]), .cmd_off(wr_cmd & bus_wdata[1]),
        .cmd_kick(wr_cmd & bus_wdata[2]),
        .tioa_lvl(lvl[3]), .tiob_lvl(lvl[4]),
        .lda_pend(stat_q[EV_LDA] & ~rd_stat),
        .ldb_pend(stat_q[EV_LDB] & ~rd_stat),
        .cnt(cnt), .cap_a(cap_a), .cap_b(cap_b), .evt(evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            rc_q   <= '0;
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            if (bus_wr && (bus_addr == A_MODE)) mode_q <= mode_t'(bus_wdata);
            if (bus_wr && (bus_addr == A_CMPC)) rc_q   <= bus_wdata[CNT_W-1:0];
            if (wr_mset) mask_q <= mask_q | bus_wdata[NEV-1:0];
            if (wr_mclr) mask_q <= mask_q & ~bus_wdata[NEV-1:0];
            stat_q <= (rd_stat ? '0 : stat_q) | evt;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:  bus_rdata = mode_q;
            A_CNT:   bus_rdata = {{(BUS_W-CNT_W){1'b0}}, cnt};
            A_CAPA:  bus_rdata = {{(BUS_W-CNT_W){1'b0}}, cap_a};
            A_CAPB:  bus_rdata = {{(BUS_W-CNT_W){1'b0}}, cap_b};
            A_CMPC:  bus_rdata = {{(BUS_W-CNT_W){1'b0}}, rc_q};
            A_STAT:  bus_rdata = {{(BUS_W-NEV){1'b0}}, stat_q};
            A_MASK:  bus_rdata = {{(BUS_W-NEV){1'b0}}, mask_q};
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |(stat_q & mask_q);

    // R12
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && (evt == '0)) |=> (stat_q == '0));
    // R13
    mask_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mclr && (&bus_wdata[NEV-1:0])) |=> !irq);
endmodule

// File: tb/test_tc_capture_channel.sv
`timescale 1ns/1ps
module test_tc_capture_channel;
    localparam int W = 8;
    localparam logic [3:0] CMD = 0, MODE = 1, CNT = 2, CAPA = 3, CAPB = 4,
                           CMPC = 5, STAT = 6, MSET = 7, MCLR = 8, MASK = 9;

    logic        clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        tioa = 0, tiob = 0, irq;
    logic [2:0]  xc = 0;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    tc_capture_channel #(.CNT_W(W)) i_tc_capture_channel (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tioa(tioa), .tiob(tiob), .xc(xc), .irq(irq)
    );

    function automatic logic [31:0] mw(int src, int inv = 0, int gate = 0,
            int hold = 0, int off = 0, int ted = 0, int tsb = 0,
            int rcr = 0, int lda = 0, int ldb = 0);
        return 32'(src | (inv << 3) | (gate << 4) | (hold << 6) | (off << 7) |
                   (ted << 8) | (tsb << 10) | (rcr << 14) | (lda << 16) | (ldb << 18));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int idx, int n);
        for (int k = 0; k < n; k++) begin
            xc[idx] = 1; idle(4);
            xc[idx] = 0; idle(4);
        end
    endtask

    task automatic set_a(logic v); tioa = v; idle(4); endtask
    task automatic set_b(logic v); tiob = v; idle(4); endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(MODE, d); chk("R1 mode", d, 0);
        rd(CNT, d);  chk("R1 counter", d, 0);
        rd(CAPA, d); chk("R1 capA", d, 0);
        rd(CAPB, d); chk("R1 capB", d, 0);
        rd(STAT, d); chk("R1 status", d, 0);
        rd(MASK, d); chk("R1 mask", d, 0);
        chk("R1 irq", 32'(irq), 0);
        rd(MSET, d); chk("R14 write-only reads zero", d, 0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        wr(MODE, mw(5));
        wr(CMD, 1); pulse(0, 3);
        rd(CNT, d); chk("R3 enabled but not started", d, 0);
        wr(CMD, 4); pulse(0, 3);
        rd(CNT, d); chk("R3 kick starts", d, 3);
        wr(CMD, 3); pulse(0, 2);
        rd(CNT, d); chk("R3 disable wins", d, 3);
        wr(CMD, 5);
        rd(CNT, d); chk("R3 kick clears", d, 0);
        pulse(0, 2);
        rd(CNT, d); chk("R2 xc0 source", d, 2);
        wr(MODE, mw(6)); wr(CMD, 5);
        pulse(0, 2); pulse(1, 3);
        rd(CNT, d); chk("R2 xc1 source", d, 3);
    endtask

    task automatic window(string tag, int src, int len, int exp);
        logic [31:0] a, b;
        wr(MODE, mw(src)); wr(CMD, 5);
        rd(CNT, a); idle(len - 1); rd(CNT, b);
        chk(tag, (b - a) & 32'hFF, 32'(exp));
    endtask

    task automatic t_prescale;
        window("R2 clk/2", 0, 100, 50);
        window("R2 clk/8", 1, 800, 100);
        window("R2 clk/32", 2, 640, 20);
        window("R2 clk/128", 3, 1280, 10);
        window("R2 clk/1024", 4, 2048, 2);
    endtask

    task automatic t_invert;
        logic [31:0] d;
        wr(MODE, mw(5, 1)); wr(CMD, 5);
        xc[0] = 1; idle(4);
        rd(CNT, d); chk("R4 inverted ignores rise", d, 0);
        xc[0] = 0; idle(4);
        rd(CNT, d); chk("R4 inverted counts fall", d, 1);
        wr(MODE, mw(5)); wr(CMD, 5);
        xc[0] = 1; idle(4);
        rd(CNT, d); chk("R4 normal counts rise", d, 1);
        xc[0] = 0; idle(4);
    endtask

    task automatic t_gate;
        logic [31:0] a, b;
        wr(MODE, mw(0, 0, 2)); wr(CMD, 5);
        rd(CNT, a); idle(99); rd(CNT, b);
        chk("R5 gate low blocks", (b - a) & 32'hFF, 0);
        xc[1] = 1; idle(4);
        rd(CNT, a); idle(99); rd(CNT, b);
        chk("R5 gate high passes", (b - a) & 32'hFF, 50);
        xc[1] = 0; idle(4);
    endtask

    task automatic t_rc;
        logic [31:0] d;
        wr(CMPC, 3);
        wr(MODE, mw(5, 0, 0, 0, 0, 0, 0, 1)); wr(CMD, 5);
        rd(STAT, d);
        pulse(0, 3);
        rd(STAT, d); chk("R6 no C match yet", d & 32'h10, 0);
        pulse(0, 1);
        rd(CNT, d); chk("R6 restart at C", d, 0);
        rd(STAT, d); chk("R6 C match flag", d & 32'h10, 32'h10);
        rd(STAT, d); chk("R12 read clears", d & 32'h10, 0);
        pulse(0, 6);
        rd(CNT, d); chk("R6 period C+1", d, 2);
        wr(MODE, mw(5)); wr(CMD, 5); rd(STAT, d);
        pulse(0, 5);
        rd(CNT, d); chk("R6 no restart when bit 14 clear", d, 5);
        rd(STAT, d); chk("R6 flag without restart", d & 32'h10, 32'h10);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        wr(MODE, mw(0)); wr(CMD, 5);
        rd(STAT, d); idle(100);
        rd(STAT, d); chk("R7 no wrap yet", d & 32'h1, 0);
        idle(600);
        rd(STAT, d); chk("R7 wrap flag", d & 32'h1, 1);
    endtask

    task automatic t_capture;
        logic [31:0] d;
        wr(MODE, mw(5, 0, 0, 0, 0, 0, 0, 0, 1, 2)); wr(CMD, 5);
        rd(STAT, d);
        pulse(0, 3); set_a(1);
        rd(CAPA, d); chk("R8 capture A on rise", d, 3);
        pulse(0, 2); set_a(0);
        rd(CAPB, d); chk("R8 capture B on fall", d, 5);
        rd(CAPA, d); chk("R8 A untouched by fall", d, 3);
        rd(STAT, d); chk("R8 load flags", d & 32'h62, 32'h60);
        set_a(1); set_a(0); set_a(1);
        rd(STAT, d); chk("R9 overrun", d & 32'h2, 32'h2);
        rd(CAPA, d); chk("R8 A reloaded", d, 5);
        pulse(0, 1);
        rd(STAT, d); chk("R6 A and B match flags", d & 32'hC, 32'hC);
        set_a(0);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        wr(MODE, mw(5, 0, 0, 1, 0, 0, 0, 0, 0, 1)); wr(CMD, 5);
        pulse(0, 2); set_a(1); pulse(0, 3);
        rd(CNT, d); chk("R10 stop on B load", d, 2);
        rd(CAPB, d); chk("R10 B loaded", d, 2);
        set_a(0); wr(CMD, 4); pulse(0, 3);
        rd(CNT, d); chk("R10 kick restarts", d, 3);
        wr(MODE, mw(5, 0, 0, 0, 1, 0, 0, 0, 0, 1)); wr(CMD, 5);
        pulse(0, 2); set_a(1); pulse(0, 2);
        rd(CNT, d); chk("R10 disable on B load", d, 2);
        set_a(0); wr(CMD, 4); pulse(0, 2);
        rd(CNT, d); chk("R10 kick alone stays off", d, 0);
        wr(CMD, 5); pulse(0, 2);
        rd(CNT, d); chk("R10 enable resumes", d, 2);
    endtask

    task automatic t_trigger;
        logic [31:0] d;
        wr(MODE, mw(5, 0, 0, 0, 0, 1, 1)); wr(CMD, 5);
        rd(STAT, d);
        pulse(0, 4); set_a(1);
        rd(CNT, d); chk("R11 tioa ignored when source is tiob", d, 4);
        set_b(1);
        rd(CNT, d); chk("R11 tiob rise clears", d, 0);
        rd(STAT, d); chk("R11 trigger flag", d & 32'h80, 32'h80);
        pulse(0, 2); set_b(0);
        rd(CNT, d); chk("R11 fall ignored for rising edge", d, 2);
        set_a(0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(CMPC, 1);
        wr(MODE, mw(5, 0, 0, 0, 0, 0, 0, 1)); wr(CMD, 5);
        rd(STAT, d);
        wr(MSET, 32'h10);
        chk("R13 irq low without event", 32'(irq), 0);
        pulse(0, 2);
        chk("R13 irq on masked event", 32'(irq), 1);
        rd(MASK, d); chk("R13 mask set", d, 32'h10);
        wr(MCLR, 0);
        chk("R13 zero clear no effect", 32'(irq), 1);
        wr(MCLR, 32'h10);
        chk("R13 irq off after clear", 32'(irq), 0);
        wr(MSET, 32'h10);
        chk("R13 irq back while flag latched", 32'(irq), 1);
        wr(MODE, mw(5));
        rd(STAT, d);
        chk("R12 irq drops after status read", 32'(irq), 0);
        rd(MASK, d); chk("R13 mask kept", d, 32'h10);
    endtask

    initial begin
        idle(3); rst = 0; idle(2);
        t_reset; t_enable; t_prescale; t_invert; t_gate;
        t_rc; t_wrap; t_capture; t_stop; t_trigger; t_irq;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule